// File: doc/BRIEF.md
# Raster Timing Generator with Frame Counter

The block walks a pixel-clocked raster and produces horizontal sync, vertical sync, a data-enable strobe and the pixel and line position inside the active area. Each line and each frame is divided into four phases in a fixed order: sync, back porch, active, front porch. Software sets the length of every phase through a length input that holds the desired length minus one. Vertical phases are counted in lines, and horizontal phases in pixel clocks.

Two scan styles are supported. In continuous video mode the raster runs for as long as `run` is high. In command mode the raster stays parked at its origin until a trigger arrives, then runs exactly one frame and parks again. A frame identifier advances once per frame. In video mode it advances when vertical sync begins, and in command mode when the vertical back porch begins. Each advance raises a one-cycle interrupt pulse and sets a sticky pending bit. When interlace is enabled, a field flag toggles after every vertical period. In that case software programs the per-field active line count, which is half the frame height minus one.

Top module: `scan_timing_gen`

## Requirements
- R1: After `rst_n` is released, all outputs are zero: `hsync`, `vsync`, `de`, `x_pos`, `y_pos`, `vphase`, `field`, `xfer_active`, `frame_id`, `frame_irq` and `irq_pend`.
- R2: When the raster advances, each line has the phases sync, back porch, active and front porch, in that order. Phase n lasts its `h_*_len` value plus one clocks, and `hsync` is high only during the horizontal sync phase.
- R3: The vertical phases follow the same order. Each lasts its `v_*_len` value plus one lines, and `vsync` is high only during vertical sync. `vphase` reads 0 for sync, 1 for back porch, 2 for active and 3 for front porch, and it is valid at any time.
- R4: `de` is high only while the raster advances and both axes are in their active phase. `x_pos` and `y_pos` count from 0 within the active phase and read 0 outside it.
- R5: In video mode, `frame_id` increments on the first pixel of vertical sync. The new value is visible in the following cycle.
- R6: In command mode the raster is held at its origin with all strobes low until `trig` is seen. `xfer_active` is high from the cycle after the trigger through the last pixel of that frame. A trigger that arrives during a transfer is ignored. `frame_id` increments on the first pixel of the vertical back porch.
- R7: `frame_irq` is a one-cycle pulse in the cycle in which `frame_id` changes. `irq_pend` is set at the same time and cleared by `irq_clr`. When a set and a clear fall in the same cycle, the set wins.
- R8: With `interlace_en` high, `field` toggles after the last pixel of every vertical period. With `interlace_en` low, `field` is held at 0.
- R9: `soft_rst` returns the raster to its origin and clears `frame_id`, `irq_pend`, `field` and `xfer_active`.
- R10: `frame_id` is `FID_W` bits wide and wraps from all-ones to zero.
- R11: While `run` is low, the raster is held at its origin and `hsync`, `vsync` and `de` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset |
| run | input | 1 | Enables the generator |
| cmd_mode | input | 1 | 1 selects command mode (one frame per trigger) |
| trig | input | 1 | Starts one frame in command mode |
| interlace_en | input | 1 | Enables field toggling |
| irq_clr | input | 1 | Clears the pending bit (write-1-to-clear) |
| h_sync_len | input | HW | Horizontal sync length minus one |
| h_back_len | input | HW | Horizontal back porch minus one |
| h_act_len | input | HW | Active pixels minus one |
| h_front_len | input | HW | Horizontal front porch minus one |
| v_sync_len | input | VW | Vertical sync lines minus one |
| v_back_len | input | VW | Vertical back porch lines minus one |
| v_act_len | input | VW | Active lines (per field) minus one |
| v_front_len | input | VW | Vertical front porch lines minus one |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active-video enable |
| x_pos | output | HW | Pixel index inside the active area |
| y_pos | output | VW | Line index inside the active area |
| vphase | output | 2 | Vertical phase code |
| field | output | 1 | Interlace field flag |
| xfer_active | output | 1 | Command-mode transfer in progress |
| frame_id | output | FID_W | Frame identifier |
| frame_irq | output | 1 | Frame-start pulse |
| irq_pend | output | 1 | Sticky frame-start pending bit |

## Verification
The clear of the pending bit and a new frame-start event can land in the same cycle, and in that case the set must win. The bench provokes this by holding `irq_clr` high across a whole frame, so that the clear request is present in the very cycle of the counter increment. The bench's behavioural model predicts that `irq_pend` reads 1 for one cycle and then drops. Every cycle is compared against the model, and the bench also counts how often a pending bit was observed alongside an active clear and a pulse. A second collision of the same kind occurs between the end of a frame in command mode and a trigger, which must not restart the transfer.

// File: rtl/scan_tg_pkg.sv
package scan_tg_pkg;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_t;

  // successor in the fixed order sync -> back -> active -> front -> sync
  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH_SYNC:  next_phase = PH_BACK;
      PH_BACK:  next_phase = PH_ACT;
      PH_ACT:   next_phase = PH_FRONT;
      default:  next_phase = PH_SYNC;
    endcase
  endfunction

  // true on the first count of the given phase
  function automatic logic phase_entry(input phase_t p, input phase_t want,
                                       input logic cnt_zero);
    phase_entry = (p == want) && cnt_zero;
  endfunction

endpackage

// File: rtl/stg_axis.sv
module stg_axis
  import scan_tg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] lim_sync,
  input  logic [CW-1:0] lim_back,
  input  logic [CW-1:0] lim_act,
  input  logic [CW-1:0] lim_front,
  output phase_t        ph,
  output logic [CW-1:0] cnt,
  output logic          at_start,
  output logic          wrap
);

  logic [CW-1:0] cur_lim;
  logic          last;

  always_comb begin
    case (ph)
      PH_SYNC: cur_lim = lim_sync;
      PH_BACK: cur_lim = lim_back;
      PH_ACT:  cur_lim = lim_act;
      default: cur_lim = lim_front;
    endcase
  end

  assign last     = (cnt == cur_lim);
  assign at_start = (cnt == '0);
  assign wrap     = step && last && (ph == PH_FRONT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_SYNC;
      cnt <= '0;
    end else if (clr) begin
      ph  <= PH_SYNC;
      cnt <= '0;
    end else if (step) begin
      if (last) begin
        cnt <= '0;
        ph  <= next_phase(ph);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/stg_frame_ctl.sv
module stg_frame_ctl #(
  parameter int FID_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             run,
  input  logic             cmd_mode,
  input  logic             trig,
  input  logic             interlace_en,
  input  logic             irq_clr,
  input  logic             frm_evt,
  input  logic             frame_end,
  output logic             busy,
  output logic [FID_W-1:0] frame_id,
  output logic             frame_irq,
  output logic             irq_pend,
  output logic             field
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      frame_id  <= '0;
      frame_irq <= 1'b0;
      irq_pend  <= 1'b0;
      field     <= 1'b0;
    end else if (soft_rst) begin
      busy      <= 1'b0;
      frame_id  <= '0;
      frame_irq <= 1'b0;
      irq_pend  <= 1'b0;
      field     <= 1'b0;
    end else begin
      busy      <= run && cmd_mode && (busy ? !frame_end : trig);
      frame_irq <= frm_evt;
      irq_pend  <= frm_evt || (irq_pend && !irq_clr);
      if (frm_evt) frame_id <= frame_id + 1'b1;
      if (!interlace_en) field <= 1'b0;
      else if (frame_end) field <= !field;
    end
  end

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_tg_pkg::*;
#(
  parameter int HW    = 12,
  parameter int VW    = 12,
  parameter int FID_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             run,
  input  logic             cmd_mode,
  input  logic             trig,
  input  logic             interlace_en,
  input  logic             irq_clr,
  input  logic [HW-1:0]    h_sync_len,
  input  logic [HW-1:0]    h_back_len,
  input  logic [HW-1:0]    h_act_len,
  input  logic [HW-1:0]    h_front_len,
  input  logic [VW-1:0]    v_sync_len,
  input  logic [VW-1:0]    v_back_len,
  input  logic [VW-1:0]    v_act_len,
  input  logic [VW-1:0]    v_front_len,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [HW-1:0]    x_pos,
  output logic [VW-1:0]    y_pos,
  output logic [1:0]       vphase,
  output logic             field,
  output logic             xfer_active,
  output logic [FID_W-1:0] frame_id,
  output logic             frame_irq,
  output logic             irq_pend
);

  phase_t          hph, vph;
  logic [HW-1:0]   hcnt;
  logic [VW-1:0]   vcnt;
  logic            h_start, v_start, line_end, frame_end;
  logic            busy, adv, hold, vsync_start, vback_start, frm_evt;

  // named internal events
  assign adv         = run && (!cmd_mode || busy);
  assign hold        = soft_rst || !run || (cmd_mode && !busy);
  assign vsync_start = adv && phase_entry(hph, PH_SYNC, h_start)
                           && phase_entry(vph, PH_SYNC, v_start);
  assign vback_start = adv && phase_entry(hph, PH_SYNC, h_start)
                           && phase_entry(vph, PH_BACK, v_start);
  assign frm_evt     = cmd_mode ? vback_start : vsync_start;

  stg_axis #(.CW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .clr(hold), .step(adv),
    .lim_sync(h_sync_len), .lim_back(h_back_len),
    .lim_act(h_act_len), .lim_front(h_front_len),
    .ph(hph), .cnt(hcnt), .at_start(h_start), .wrap(line_end)
  );

  stg_axis #(.CW(VW)) u_v (
    .clk(clk), .rst_n(rst_n), .clr(hold), .step(line_end),
    .lim_sync(v_sync_len), .lim_back(v_back_len),
    .lim_act(v_act_len), .lim_front(v_front_len),
    .ph(vph), .cnt(vcnt), .at_start(v_start), .wrap(frame_end)
  );

  stg_frame_ctl #(.FID_W(FID_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run),
    .cmd_mode(cmd_mode), .trig(trig), .interlace_en(interlace_en),
    .irq_clr(irq_clr), .frm_evt(frm_evt), .frame_end(frame_end),
    .busy(busy), .frame_id(frame_id), .frame_irq(frame_irq),
    .irq_pend(irq_pend), .field(field)
  );

  assign hsync       = adv && (hph == PH_SYNC);
  assign vsync       = adv && (vph == PH_SYNC);
  assign de          = adv && (hph == PH_ACT) && (vph == PH_ACT);
  assign x_pos       = (hph == PH_ACT) ? hcnt : '0;
  assign y_pos       = (vph == PH_ACT) ? vcnt : '0;
  assign vphase      = vph;
  assign xfer_active = busy;

endmodule

// File: rtl/scan_timing_gen_chk.sv
module scan_timing_gen_chk #(
  parameter int FID_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             cmd_mode,
  input logic             irq_clr,
  input logic             xfer_active,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [1:0]       vphase,
  input logic             frame_irq,
  input logic             irq_pend,
  input logic [FID_W-1:0] frame_id
);

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);

  // R7
  pend_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> irq_pend);

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_clr) && !frame_irq) |-> !irq_pend);

  // R5
  fid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> (frame_id == FID_W'($past(frame_id) + 1'b1)));

  // R9
  fid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_irq && !$past(soft_rst)) |-> $stable(frame_id));

  // R9
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (frame_id == '0 && !irq_pend && !xfer_active));

  // R4
  de_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (vphase == 2'd2 && !hsync && !vsync));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode && !xfer_active) |-> (!hsync && !vsync && !de));

endmodule

bind scan_timing_gen scan_timing_gen_chk #(.FID_W(FID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_mode(cmd_mode),
  .irq_clr(irq_clr), .xfer_active(xfer_active), .hsync(hsync),
  .vsync(vsync), .de(de), .vphase(vphase), .frame_irq(frame_irq),
  .irq_pend(irq_pend), .frame_id(frame_id)
);

// File: tb/scan_timing_gen_test.sv
module scan_timing_gen_test;

  localparam int HW = 12, VW = 12, FW = 4, FMOD = 16;
  localparam int HS = 2, HB = 3, HA = 8, HF = 2, HT = HS + HB + HA + HF;
  // interlaced frame of 8 active lines => 4 lines per field, programmed 3
  localparam int VS = 1, VB = 2, VA = 4, VF = 1, VT = VS + VB + VA + VF;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, run = 1'b0, cmd_mode = 1'b0;
  logic trig = 1'b0, interlace_en = 1'b0, irq_clr = 1'b0;
  logic hsync, vsync, de, field, xfer_active, frame_irq, irq_pend;
  logic [HW-1:0] x_pos;
  logic [VW-1:0] y_pos;
  logic [1:0] vphase;
  logic [FW-1:0] frame_id;

  int checks = 0, errors = 0;
  bit cmp_en = 0;
  int coll_seen = 0, wrap_seen = 0;
  int prev_fid = 0;

  // reference model state
  int m_hp = 0, m_vl = 0, m_fid = 0;
  bit m_busy = 0, m_irq = 0, m_pend = 0, m_field = 0;

  always #2 clk = ~clk;

  scan_timing_gen #(.HW(HW), .VW(VW), .FID_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run),
    .cmd_mode(cmd_mode), .trig(trig), .interlace_en(interlace_en),
    .irq_clr(irq_clr),
    .h_sync_len(HW'(HS - 1)), .h_back_len(HW'(HB - 1)),
    .h_act_len(HW'(HA - 1)), .h_front_len(HW'(HF - 1)),
    .v_sync_len(VW'(VS - 1)), .v_back_len(VW'(VB - 1)),
    .v_act_len(VW'(VA - 1)), .v_front_len(VW'(VF - 1)),
    .hsync(hsync), .vsync(vsync), .de(de), .x_pos(x_pos), .y_pos(y_pos),
    .vphase(vphase), .field(field), .xfer_active(xfer_active),
    .frame_id(frame_id), .frame_irq(frame_irq), .irq_pend(irq_pend)
  );

  function automatic int phase_of(int p, int a, int b, int c);
    if (p < a) return 0;
    if (p < a + b) return 1;
    if (p < a + b + c) return 2;
    return 3;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    bit adv, vs0, bp0, fe, frm, hold;
    if (!rst_n || soft_rst) begin
      m_hp = 0; m_vl = 0; m_fid = 0; m_busy = 0;
      m_irq = 0; m_pend = 0; m_field = 0;
    end else begin
      adv  = run && (!cmd_mode || m_busy);
      vs0  = adv && m_vl == 0 && m_hp == 0;
      bp0  = adv && m_vl == VS && m_hp == 0;
      fe   = adv && m_hp == HT - 1 && m_vl == VT - 1;
      frm  = cmd_mode ? bp0 : vs0;
      hold = !run || (cmd_mode && !m_busy);
      m_irq  = frm;
      if (frm) m_fid = (m_fid + 1) % FMOD;
      m_pend = frm || (m_pend && !irq_clr);
      if (!interlace_en) m_field = 0;
      else if (fe) m_field = !m_field;
      m_busy = run && cmd_mode && (m_busy ? !fe : trig);
      if (hold) begin
        m_hp = 0; m_vl = 0;
      end else if (adv) begin
        if (m_hp == HT - 1) begin
          m_hp = 0;
          m_vl = (m_vl == VT - 1) ? 0 : m_vl + 1;
        end else m_hp = m_hp + 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      bit ea;
      int eh, ev;
      string fid_req;
      ea = run && (!cmd_mode || m_busy);
      eh = phase_of(m_hp, HS, HB, HA);
      ev = phase_of(m_vl, VS, VB, VA);
      fid_req = cmd_mode ? "R6 frame_id" : "R5 frame_id";
      chk(hsync == (ea && eh == 0), "R2 hsync", hsync, ea && eh == 0);
      chk(vsync == (ea && ev == 0), "R3 vsync", vsync, ea && ev == 0);
      chk(vphase == ev, "R3 vphase", vphase, ev);
      chk(de == (ea && eh == 2 && ev == 2), "R4 de", de, ea && eh == 2 && ev == 2);
      chk(x_pos == ((eh == 2) ? m_hp - HS - HB : 0), "R4 x_pos", x_pos,
          (eh == 2) ? m_hp - HS - HB : 0);
      chk(y_pos == ((ev == 2) ? m_vl - VS - VB : 0), "R4 y_pos", y_pos,
          (ev == 2) ? m_vl - VS - VB : 0);
      chk(frame_id == m_fid, fid_req, frame_id, m_fid);
      chk(xfer_active == m_busy, "R6 xfer_active", xfer_active, m_busy);
      chk(frame_irq == m_irq, "R7 frame_irq", frame_irq, m_irq);
      chk(irq_pend == m_pend, "R7 irq_pend", irq_pend, m_pend);
      chk(field == m_field, "R8 field", field, m_field);
      if (irq_clr && frame_irq) begin
        coll_seen++;
        chk(irq_pend, "R7 set-wins", irq_pend, 1);
      end
      if (frame_irq) begin
        if (prev_fid == FMOD - 1 && frame_id == 0) wrap_seen++;
      end
      prev_fid = frame_id;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({hsync, vsync, de, field, xfer_active, frame_irq, irq_pend} == 7'b0,
        "R1 strobes", {hsync, vsync, de, field, xfer_active, frame_irq, irq_pend}, 0);
    chk(frame_id == 0 && x_pos == 0 && y_pos == 0 && vphase == 0,
        "R1 counters", frame_id, 0);
    cmp_en = 1;
    cyc(5);
    @(negedge clk);
    // R11 idle while run low
    chk(!hsync && !vsync && !de, "R11 idle", {hsync, vsync, de}, 0);
    chk(x_pos == 0 && vphase == 0, "R11 origin", x_pos, 0);

    // video mode, several frames (R2 R3 R4 R5)
    @(posedge clk); #1 run = 1'b1;
    cyc(3 * HT * VT);
    // R7 collision: clear held across a frame start
    irq_clr = 1'b1;
    cyc(HT * VT + 10);
    irq_clr = 1'b0;
    chk(coll_seen > 0, "R7 collision seen", coll_seen, 1);
    cyc(20);
    // R8 interlace
    interlace_en = 1'b1;
    cyc(3 * HT * VT);
    // R10 wrap
    cyc(17 * HT * VT);
    chk(wrap_seen > 0, "R10 wrap", wrap_seen, 1);
    interlace_en = 1'b0;
    // R9 soft reset mid-frame
    cyc(37);
    soft_rst = 1'b1;
    cyc(1);
    soft_rst = 1'b0;
    @(negedge clk);
    chk(frame_id == 0 && !irq_pend && !field, "R9 soft_rst", frame_id, 0);
    chk(vphase == 0 && x_pos == 0, "R9 origin", vphase, 0);

    // command mode (R6)
    cyc(50);
    cmd_mode = 1'b1;
    cyc(20);
    @(negedge clk);
    chk(!xfer_active && !hsync && !vsync, "R6 parked", xfer_active, 0);
    base = frame_id;
    @(posedge clk); #1 trig = 1'b1;
    cyc(1);
    trig = 1'b0;
    @(negedge clk);
    chk(xfer_active, "R6 start", xfer_active, 1);
    cyc(40);
    trig = 1'b1;   // ignored during transfer
    cyc(1);
    trig = 1'b0;
    cyc(HT * VT);
    @(negedge clk);
    chk(!xfer_active, "R6 one frame", xfer_active, 0);
    chk(frame_id == (base + 1) % FMOD, "R6 count", frame_id, (base + 1) % FMOD);
    @(posedge clk); #1 trig = 1'b1;
    cyc(1);
    trig = 1'b0;
    cyc(HT * VT + 10);
    @(negedge clk);
    chk(frame_id == (base + 2) % FMOD, "R6 second", frame_id, (base + 2) % FMOD);
    finish_run();
  end

endmodule